// File: doc/BRIEF.md
# BCD Time Alarm Comparator

This block watches a running time of day held as binary-coded decimal (seconds, minutes, hours, day) and raises an alarm when it reaches a programmed time. Four 8-bit alarm registers hold the target. Their low seven bits are the BCD value and bit 7 is a per-field mask. Setting a field's mask bit drops that field from the compare, which sets how often the alarm repeats: once a minute, once an hour, once a day, and so on.

The registers sit behind a simple access port. Each access either uses an explicit address or steps through the registers in burst order. A match raises a sticky alarm flag and drives an active-low interrupt. If the match happens while the device sleeps, the block issues a wake request. The interrupt is then held off until the device has left sleep and the clock-ready input shows that the clock is usable. Reading the status clears the flag and releases the interrupt.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset, `alarm_flag` is 0, `irq_n` is 1, `wake_req` is 0, and all four alarm registers read 0x00.
- R2: A write with `acc_burst`=0 stores `acc_wdata` in the register at `acc_addr`, where 0 is seconds, 1 is minutes, 2 is hours and 3 is day. A read with `acc_burst`=0 shows that register on `acc_rdata` in the same cycle.
- R3: After a non-burst access to address A, the burst pointer holds A+1. Each access with `acc_burst`=1 uses the pointer and then advances it in the order seconds, minutes, hours, day. After day it wraps back to seconds.
- R4: A field takes part in the match only when bit 7 of its alarm register is 0. In that case, bits 6:0 of the register must equal bits 6:0 of the matching time input. A field whose bit 7 is 1 always counts as matching.
- R5: An unmasked field whose low nibble is above 9 never matches, even when the time input carries the same code.
- R6: While `alarm_en` is 0, the alarm flag is never set.
- R7: An alarm fires only on the cycle where the enabled match condition goes from false to true. A match that stays true does not fire again after the flag is cleared.
- R8: The flag goes to 1 one cycle after an enabled match appears, whether or not `sleep` is high.
- R9: `irq_n` is low exactly when, on the previous edge, the updated flag was 1 while `sleep` was 0 and `clk_ready` was 1.
- R10: An alarm that fires while `sleep` is 1 sets `wake_req` on the next cycle. `wake_req` stays high until `sleep` is sampled at 0.
- R11: A cycle with `status_rd` high clears the flag and releases `irq_n` on the next edge. An alarm firing in that same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_sec | input | 8 | Current seconds, BCD |
| time_min | input | 8 | Current minutes, BCD |
| time_hour | input | 8 | Current hours, BCD |
| time_day | input | 8 | Current day, BCD |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_burst | input | 1 | Use and advance the burst pointer |
| acc_addr | input | 2 | Register address for non-burst access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data of the addressed register |
| alarm_en | input | 1 | Alarm enable |
| sleep | input | 1 | Device is in sleep mode |
| clk_ready | input | 1 | Clock output is available |
| status_rd | input | 1 | Status read; clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm status |
| irq_n | output | 1 | Active-low interrupt |
| wake_req | output | 1 | Wake request raised by an alarm during sleep |

## Verification
The hardest case to reach from the ports is a fresh rising match that arrives while `sleep` is high. The sequence then has to continue through the release from sleep with `clk_ready` still low, and only later go ready. To fire an alarm at all, the match condition must first be broken and then restored.

Directed sequences build this sequence step by step: they break the match, re-establish it under sleep, and then toggle `sleep` and `clk_ready` separately. Random stimulus draws time values and register contents from a small pool with mixed mask bits, so that fresh matches occur often. Those random cycles are checked against a cycle model kept in the bench.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int FIELD_W    = 8;
  localparam int ADDR_W     = $clog2(NUM_FIELDS);
  localparam logic [3:0] BCD_MAX = 4'd9;

  typedef enum logic [1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DAY  = 2'd3
  } field_e;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile #(
  parameter int NF = 4,
  parameter int W  = 8,
  localparam int AW = $clog2(NF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_wr,
  input  logic            acc_rd,
  input  logic            acc_burst,
  input  logic [AW-1:0]   acc_addr,
  input  logic [W-1:0]    acc_wdata,
  output logic [W-1:0]    acc_rdata,
  output logic [NF*W-1:0] regs_flat
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] sel;
  logic [W-1:0]  regs [NF];

  assign sel = acc_burst ? ptr_q : acc_addr;

  always_comb begin
    ptr_d = ptr_q;
    if (acc_wr || acc_rd) ptr_d = AW'(sel + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < NF; i++) begin : g_reg
    logic we;
    assign we = acc_wr && (sel == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[i] <= '0;
      else if (we) regs[i] <= acc_wdata;
    end
    assign regs_flat[i*W +: W] = regs[i];
  end

  assign acc_rdata = regs[sel];
endmodule

// File: rtl/field_compare.sv
module field_compare
  import bcd_alarm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] alarm_reg,
  input  logic [W-1:0] cur_time,
  output logic         field_ok
);
  logic masked, digit_ok, equal;

  always_comb begin
    masked   = alarm_reg[W-1];
    digit_ok = (alarm_reg[3:0] <= BCD_MAX);
    equal    = (alarm_reg[W-2:0] == cur_time[W-2:0]);
    field_ok = masked || (digit_ok && equal);
  end
endmodule

// File: rtl/alarm_event_ctrl.sv
module alarm_event_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic all_match,
  input  logic alarm_en,
  input  logic sleep,
  input  logic clk_ready,
  input  logic status_rd,
  output logic alarm_flag,
  output logic irq_n,
  output logic wake_req
);
  logic armed, armed_q, hit;
  logic flag_d, irq_d, wake_d;

  always_comb begin
    armed  = alarm_en && all_match;
    hit    = armed && !armed_q;
    flag_d = hit || (alarm_flag && !status_rd);
    irq_d  = !(flag_d && !sleep && clk_ready);
    wake_d = sleep && (hit || wake_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      alarm_flag <= 1'b0;
      irq_n      <= 1'b1;
      wake_req   <= 1'b0;
    end else begin
      armed_q    <= armed;
      alarm_flag <= flag_d;
      irq_n      <= irq_d;
      wake_req   <= wake_d;
    end
  end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FIELD_W-1:0]  time_sec,
  input  logic [FIELD_W-1:0]  time_min,
  input  logic [FIELD_W-1:0]  time_hour,
  input  logic [FIELD_W-1:0]  time_day,
  input  logic                acc_wr,
  input  logic                acc_rd,
  input  logic                acc_burst,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [FIELD_W-1:0]  acc_wdata,
  output logic [FIELD_W-1:0]  acc_rdata,
  input  logic                alarm_en,
  input  logic                sleep,
  input  logic                clk_ready,
  input  logic                status_rd,
  output logic                alarm_flag,
  output logic                irq_n,
  output logic                wake_req
);
  logic [NUM_FIELDS*FIELD_W-1:0] regs_flat, time_flat;
  logic [NUM_FIELDS-1:0]         field_ok;
  logic                          all_match;

  assign time_flat = {time_day, time_hour, time_min, time_sec};

  alarm_regfile #(.NF(NUM_FIELDS), .W(FIELD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_burst(acc_burst),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .regs_flat(regs_flat)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
    field_compare #(.W(FIELD_W)) u_cmp (
      .alarm_reg(regs_flat[f*FIELD_W +: FIELD_W]),
      .cur_time (time_flat[f*FIELD_W +: FIELD_W]),
      .field_ok (field_ok[f])
    );
  end

  assign all_match = &field_ok;

  alarm_event_ctrl u_evt (
    .clk(clk), .rst_n(rst_n), .all_match(all_match),
    .alarm_en(alarm_en), .sleep(sleep), .clk_ready(clk_ready),
    .status_rd(status_rd), .alarm_flag(alarm_flag),
    .irq_n(irq_n), .wake_req(wake_req)
  );
endmodule

// File: rtl/bcd_alarm_checker.sv
module bcd_alarm_checker (
  input logic clk,
  input logic rst_n,
  input logic alarm_en,
  input logic sleep,
  input logic clk_ready,
  input logic status_rd,
  input logic alarm_flag,
  input logic irq_n,
  input logic wake_req
);
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> alarm_flag); // R9
  AST_IRQ_AWAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(!sleep) && $past(clk_ready))); // R9
  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(alarm_en)); // R6
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> ($past(sleep) && alarm_flag)); // R10
  AST_WAKE_DROPS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> !wake_req); // R10
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !alarm_en) |=> (!alarm_flag && irq_n)); // R11
  AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_flag) |-> $past(status_rd)); // R11
endmodule

bind bcd_alarm_match bcd_alarm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en), .sleep(sleep),
  .clk_ready(clk_ready), .status_rd(status_rd), .alarm_flag(alarm_flag),
  .irq_n(irq_n), .wake_req(wake_req)
);

// File: tb/sim_bcd_alarm_match.sv
module sim_bcd_alarm_match;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] t [4];
  logic acc_wr, acc_rd, acc_burst;
  logic [1:0] acc_addr;
  logic [7:0] acc_wdata, acc_rdata;
  logic alarm_en, sleep, clk_ready, status_rd;
  logic alarm_flag, irq_n, wake_req;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_regs [4];
  logic [1:0] m_ptr;
  logic m_flag, m_irq_n, m_wake, m_armed_q;

  always #10 clk = ~clk;

  bcd_alarm_match u0 (
    .clk(clk), .rst_n(rst_n),
    .time_sec(t[0]), .time_min(t[1]), .time_hour(t[2]), .time_day(t[3]),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_burst(acc_burst),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .alarm_en(alarm_en), .sleep(sleep), .clk_ready(clk_ready),
    .status_rd(status_rd), .alarm_flag(alarm_flag), .irq_n(irq_n),
    .wake_req(wake_req)
  );

  function automatic logic f_match();
    logic ok = 1'b1;
    for (int f = 0; f < 4; f++) begin
      if (!m_regs[f][7]) begin
        if (m_regs[f][3:0] > 4'd9 || m_regs[f][6:0] != t[f][6:0]) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    acc_wr = 0; acc_rd = 0; acc_burst = 0; acc_addr = 0; acc_wdata = 0;
    status_rd = 0;
  endtask

  // Inputs are set at a negedge; this applies one clock edge to DUT and model.
  task automatic step();
    logic [1:0] idx;
    logic armed, hit;
    #1;
    idx = acc_burst ? m_ptr : acc_addr;
    if (acc_rd) check("R2/R3 rdata", acc_rdata, m_regs[idx]);
    armed = alarm_en && f_match();
    hit   = armed && !m_armed_q;
    m_armed_q = armed;
    if (acc_wr) m_regs[idx] = acc_wdata;
    if (acc_wr || acc_rd) m_ptr = idx + 2'd1;
    m_flag  = hit || (m_flag && !status_rd);
    m_irq_n = !(m_flag && !sleep && clk_ready);
    m_wake  = sleep && (hit || m_wake);
    @(negedge clk);
    check("R8 alarm_flag", {7'd0, alarm_flag}, {7'd0, m_flag});
    check("R9 irq_n", {7'd0, irq_n}, {7'd0, m_irq_n});
    check("R10 wake_req", {7'd0, wake_req}, {7'd0, m_wake});
  endtask

  task automatic wr(logic burst, logic [1:0] a, logic [7:0] d);
    idle_inputs(); acc_wr = 1; acc_burst = burst; acc_addr = a; acc_wdata = d;
    step(); idle_inputs();
  endtask

  task automatic rd(logic burst, logic [1:0] a, string tag, logic [7:0] exp);
    idle_inputs(); acc_rd = 1; acc_burst = burst; acc_addr = a;
    #1 check(tag, acc_rdata, exp);
    step(); idle_inputs();
  endtask

  function automatic logic [7:0] pick();
    case ($urandom % 6)
      0: return 8'h00;
      1: return 8'h15;
      2: return 8'h30;
      3: return 8'h59;
      4: return 8'h3A;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; idle_inputs();
    alarm_en = 0; sleep = 0; clk_ready = 1;
    for (int f = 0; f < 4; f++) begin t[f] = 8'h00; m_regs[f] = 8'h00; end
    m_ptr = 0; m_flag = 0; m_irq_n = 1; m_wake = 0; m_armed_q = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 flag", {7'd0, alarm_flag}, 8'd0);
    check("R1 irq_n", {7'd0, irq_n}, 8'd1);
    check("R1 wake", {7'd0, wake_req}, 8'd0);
    for (int f = 0; f < 4; f++) rd(0, 2'(f), "R1 reg reset", 8'h00);

    // R2 single access
    wr(0, 2'd2, 8'h23);
    rd(0, 2'd2, "R2 hour readback", 8'h23);

    // R3 burst order and wrap: non-burst access to day points at seconds
    wr(0, 2'd3, 8'h01);
    wr(1, 2'd0, 8'h11);
    wr(1, 2'd0, 8'h22);
    wr(1, 2'd0, 8'h33);
    wr(1, 2'd0, 8'h44);
    rd(0, 2'd0, "R3 sec", 8'h11);
    rd(0, 2'd1, "R3 min", 8'h22);
    rd(0, 2'd2, "R3 hour", 8'h33);
    rd(1, 2'd0, "R3 burst day", 8'h44);
    rd(1, 2'd0, "R3 burst wrap to sec", 8'h11);

    // R4 masked seconds, match on min/hour/day
    wr(0, 2'd0, 8'h80); wr(0, 2'd1, 8'h30); wr(0, 2'd2, 8'h12); wr(0, 2'd3, 8'h05);
    t[0] = 8'h47; t[1] = 8'h30; t[2] = 8'h12; t[3] = 8'h05;
    alarm_en = 1;
    step();
    check("R4 masked field match flag", {7'd0, alarm_flag}, 8'd1);
    check("R4 irq_n low", {7'd0, irq_n}, 8'd0);

    // R11 and R7: clear, match persists, no refire
    status_rd = 1; step(); status_rd = 0;
    check("R11 flag cleared", {7'd0, alarm_flag}, 8'd0);
    check("R11 irq released", {7'd0, irq_n}, 8'd1);
    t[0] = 8'h48; step(); step();
    check("R7 no refire while matching", {7'd0, alarm_flag}, 8'd0);

    // R5 invalid BCD digit never matches
    t[1] = 8'h31; step();
    wr(0, 2'd1, 8'h3A); t[1] = 8'h3A; step(); step();
    check("R5 nibble above 9", {7'd0, alarm_flag}, 8'd0);

    // R6 disabled alarm
    wr(0, 2'd1, 8'h3B & 8'h39); t[1] = 8'h31; step();
    alarm_en = 0; t[1] = 8'h39; step(); step();
    check("R6 disabled no flag", {7'd0, alarm_flag}, 8'd0);

    // R10 alarm during sleep: wake, irq held until awake and ready
    t[1] = 8'h31; alarm_en = 1; step();
    sleep = 1; clk_ready = 0; t[1] = 8'h39; step();
    check("R8 flag set in sleep", {7'd0, alarm_flag}, 8'd1);
    check("R10 wake_req", {7'd0, wake_req}, 8'd1);
    check("R9 irq held in sleep", {7'd0, irq_n}, 8'd1);
    step();
    check("R10 wake held", {7'd0, wake_req}, 8'd1);
    sleep = 0; step();
    check("R10 wake dropped", {7'd0, wake_req}, 8'd0);
    check("R9 irq waits clk_ready", {7'd0, irq_n}, 8'd1);
    clk_ready = 1; step();
    check("R9 irq low when ready", {7'd0, irq_n}, 8'd0);
    status_rd = 1; step(); status_rd = 0;

    // Random phase against the bench model
    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      for (int f = 0; f < 4; f++) if ($urandom % 4 == 0) t[f] = pick();
      case ($urandom % 10)
        0: begin acc_wr = 1; acc_wdata = pick() | (($urandom % 3 == 0) ? 8'h80 : 8'h00); end
        1: acc_rd = 1;
        default: ;
      endcase
      acc_burst = 1'($urandom);
      acc_addr  = 2'($urandom);
      alarm_en  = ($urandom % 10) != 0;
      if ($urandom % 16 == 0) sleep = ~sleep;
      if ($urandom % 8 == 0) clk_ready = ~clk_ready;
      status_rd = ($urandom % 12) == 0;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule